// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sits beside a small 8-bit processor core and puts the chip into one of two sleep states when software asks. A one-byte power-control write carries two command bits. Bit 0 asks for idle. In idle the processor clock is gated off, but the peripheral clock keeps running for the serial port, the timers and the interrupt logic. Bit 1 asks for power-down. In power-down both clock enables drop, and the block asks the oscillator to stop. While either state lasts, the block also overrides the two external bus strobes, the address-latch strobe and the program-fetch strobe.

Idle ends on any pending enabled interrupt. Power-down ends only through an external interrupt pin that is enabled and configured as level-triggered. Pulling that pin low restarts the oscillator. The pin must then stay low for a fixed number of oscillator cycles, and the exit completes when the pin goes high again. Whenever a sleep state ends, the block re-opens the processor clock and sends a one-cycle wake pulse to the interrupt controller on the same edge. An asynchronous hardware reset ends either state at once.

Top module: `pwrModeCtl`

## Requirements
- R1: After reset the block is in run mode: cpuClkEn, perClkEn and oscRun are 1, and wakePulse is 0.
- R2: In run mode, a write whose bit 0 is set and whose bit 1 is clear enters idle on that clock edge: cpuClkEn becomes 0 and perClkEn stays 1.
- R3: In run mode, a write whose bit 1 is set enters power-down on that edge, whatever bit 0 holds: cpuClkEn and perClkEn become 0, and oscRun is 0 unless a wake request is present.
- R4: In run mode addrStrobe and progStrobe follow cpuAddrStrobe and cpuProgStrobe. In idle both strobes are 1, and in power-down both are 0.
- R5: In idle, intPending sampled high at an edge returns the block to run mode on that edge.
- R6: In power-down, intPending, a low pin whose extIntLevel bit is 0, and a low pin whose extIntEn bit is 0 are all ignored: oscRun stays 0 and the block stays asleep.
- R7: In power-down, oscRun is 1 while at least one pin is low with both its extIntEn bit and its extIntLevel bit at 1 (a qualified pin; extIntN is active low).
- R8: After a qualified pin has been sampled low on WAKE_CYCLES consecutive edges, the first edge at which no qualified pin is low returns the block to run mode.
- R9: If the qualified pins are released before WAKE_CYCLES low edges, the block stays in power-down and the count starts again from zero on the next low level.
- R10: On each exit from idle or power-down, wakePulse is high for exactly one cycle, in the same cycle that cpuClkEn returns to 1.
- R11: Asserting rstN low returns the block from idle or power-down to run mode at once, without waiting for a clock edge.
- R12: Writes that set neither bit 0 nor bit 1 do not change the mode, and writes made while the block is asleep are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| regWrEn | input | 1 | Power-control register write strobe |
| regWrData | input | 8 | Write data; bit 0 is the idle command, bit 1 the power-down command |
| intPending | input | 1 | Some enabled interrupt is pending |
| extIntN | input | NEXT | External interrupt pins, active low |
| extIntEn | input | NEXT | Per-pin interrupt enable |
| extIntLevel | input | NEXT | Per-pin trigger type: 1 level, 0 edge |
| cpuAddrStrobe | input | 1 | Address-latch strobe from the core |
| cpuProgStrobe | input | 1 | Program-fetch strobe from the core |
| cpuClkEn | output | 1 | Processor clock enable |
| perClkEn | output | 1 | Peripheral clock enable |
| oscRun | output | 1 | Oscillator run request |
| addrStrobe | output | 1 | Address-latch strobe at the pins |
| progStrobe | output | 1 | Program-fetch strobe at the pins |
| wakePulse | output | 1 | One-cycle wake indication to the interrupt controller |

## Verification
The bench holds a qualified pin low for WAKE_CYCLES-1 edges and then for exactly WAKE_CYCLES edges. A design with an off-by-one window would either stay asleep on the second release or wake on the first. It drives a pending interrupt, an edge-configured pin and a disabled pin during power-down. A controller that treated power-down like idle would raise oscRun or wake from these. It writes 03h to check that power-down wins over idle, writes 00h and FCh to check that they are ignored, and writes during idle to confirm that a sleeping core cannot change the mode. It asserts reset asynchronously during both sleep states, and it compares the wake pulse and both strobes on every cycle, so a stretched pulse or a strobe left following the core would be reported.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int IDLE_BIT  = 0;
  localparam int PDOWN_BIT = 1;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pmMode_t;

  // strobes from control to datapath
  typedef struct packed {
    pmMode_t mode;
    logic    cntInc;
    logic    cntClr;
  } ctlStrb_t;

endpackage

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int NEXT        = 2,
  parameter int WAKE_CYCLES = 1024
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrb_t        strb,
  input  logic [NEXT-1:0] extIntN,
  input  logic [NEXT-1:0] extIntEn,
  input  logic [NEXT-1:0] extIntLevel,
  input  logic            cpuAddrStrobe,
  input  logic            cpuProgStrobe,
  output logic            wakeReq,
  output logic            armed,
  output logic            cpuClkEn,
  output logic            perClkEn,
  output logic            oscRun,
  output logic            addrStrobe,
  output logic            progStrobe
);

  localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WAKE_CYCLES);

  logic [NEXT-1:0]  pinQual;
  logic [CNT_W-1:0] lowCnt;

  // per-pin qualification: enabled, level-triggered, driven low
  genvar gi;
  generate
    for (gi = 0; gi < NEXT; gi++) begin : g_pin
      assign pinQual[gi] = extIntEn[gi] & extIntLevel[gi] & ~extIntN[gi];
    end
  endgenerate

  assign wakeReq = |pinQual;

  // consecutive low-cycle counter, saturating at the window length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (strb.cntClr) begin
      lowCnt <= '0;
    end else if (strb.cntInc && (lowCnt != CNT_MAX)) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign armed = (lowCnt == CNT_MAX);

  // clock enables and strobe levels per mode
  always_comb begin
    cpuClkEn   = 1'b0;
    perClkEn   = 1'b0;
    oscRun     = wakeReq;
    addrStrobe = 1'b0;
    progStrobe = 1'b0;
    unique case (strb.mode)
      MODE_RUN: begin
        cpuClkEn   = 1'b1;
        perClkEn   = 1'b1;
        oscRun     = 1'b1;
        addrStrobe = cpuAddrStrobe;
        progStrobe = cpuProgStrobe;
      end
      MODE_IDLE: begin
        perClkEn   = 1'b1;
        oscRun     = 1'b1;
        addrStrobe = 1'b1;
        progStrobe = 1'b1;
      end
      default: begin
        oscRun     = wakeReq;
      end
    endcase
  end

endmodule

// File: rtl/pmc_control.sv
module pmc_control
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     regWrEn,
  input  logic     wrIdle,
  input  logic     wrPdown,
  input  logic     intPending,
  input  logic     wakeReq,
  input  logic     armed,
  output ctlStrb_t strb,
  output logic     wakePulse
);

  pmMode_t modeQ, modeNext;
  logic    exitNow;

  always_comb begin
    modeNext = modeQ;
    exitNow  = 1'b0;
    unique case (modeQ)
      MODE_RUN: begin
        if (regWrEn && wrPdown) begin
          modeNext = MODE_PDOWN;
        end else if (regWrEn && wrIdle) begin
          modeNext = MODE_IDLE;
        end
      end
      MODE_IDLE: begin
        if (intPending) begin
          modeNext = MODE_RUN;
          exitNow  = 1'b1;
        end
      end
      default: begin
        if (!wakeReq && armed) begin
          modeNext = MODE_RUN;
          exitNow  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MODE_RUN;
      wakePulse <= 1'b0;
    end else begin
      modeQ     <= modeNext;
      wakePulse <= exitNow;
    end
  end

  always_comb begin
    strb.mode   = modeQ;
    strb.cntInc = (modeQ == MODE_PDOWN) && wakeReq;
    strb.cntClr = (modeQ != MODE_PDOWN) || !wakeReq;
  end

endmodule

// File: rtl/pwrModeCtl.sv
module pwrModeCtl
  import pmc_pkg::*;
#(
  parameter int NEXT        = 2,
  parameter int WAKE_CYCLES = 1024
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic [7:0]      regWrData,
  input  logic            intPending,
  input  logic [NEXT-1:0] extIntN,
  input  logic [NEXT-1:0] extIntEn,
  input  logic [NEXT-1:0] extIntLevel,
  input  logic            cpuAddrStrobe,
  input  logic            cpuProgStrobe,
  output logic            cpuClkEn,
  output logic            perClkEn,
  output logic            oscRun,
  output logic            addrStrobe,
  output logic            progStrobe,
  output logic            wakePulse
);

  ctlStrb_t strb;
  logic     wakeReq;
  logic     armed;
  logic     unusedWrHi;

  assign unusedWrHi = ^regWrData[7:2];

  pmc_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .wrIdle     (regWrData[IDLE_BIT]),
    .wrPdown    (regWrData[PDOWN_BIT]),
    .intPending (intPending),
    .wakeReq    (wakeReq),
    .armed      (armed),
    .strb       (strb),
    .wakePulse  (wakePulse)
  );

  pmc_datapath #(
    .NEXT        (NEXT),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .extIntN       (extIntN),
    .extIntEn      (extIntEn),
    .extIntLevel   (extIntLevel),
    .cpuAddrStrobe (cpuAddrStrobe),
    .cpuProgStrobe (cpuProgStrobe),
    .wakeReq       (wakeReq),
    .armed         (armed),
    .cpuClkEn      (cpuClkEn),
    .perClkEn      (perClkEn),
    .oscRun        (oscRun),
    .addrStrobe    (addrStrobe),
    .progStrobe    (progStrobe)
  );

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int WAKE_CYCLES = 1024
) (
  input logic clk,
  input logic rstN,
  input logic cpuClkEn,
  input logic perClkEn,
  input logic oscRun,
  input logic addrStrobe,
  input logic progStrobe,
  input logic wakePulse,
  input logic cpuAddrStrobe,
  input logic cpuProgStrobe
);

  localparam int CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(WAKE_CYCLES);

  logic [CW-1:0] lowSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowSeen <= '0;
    end else if (!perClkEn && oscRun) begin
      if (lowSeen != CMAX) lowSeen <= lowSeen + 1'b1;
    end else begin
      lowSeen <= '0;
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse); // R10
  AST_PULSE_WITH_CLK: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (cpuClkEn && !$past(cpuClkEn))); // R10
  AST_RUN_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |-> (addrStrobe == cpuAddrStrobe && progStrobe == cpuProgStrobe)); // R4
  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    (perClkEn && !cpuClkEn) |-> (addrStrobe && progStrobe)); // R4
  AST_PDOWN_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    !perClkEn |-> (!addrStrobe && !progStrobe && !cpuClkEn)); // R4
  AST_PDOWN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!oscRun && !$past(oscRun)) |=> !cpuClkEn); // R6
  AST_WAKE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (perClkEn && !$past(perClkEn)) |-> ($past(lowSeen) == CMAX)); // R8

endmodule

bind pwrModeCtl pmc_checker #(.WAKE_CYCLES(WAKE_CYCLES)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .cpuClkEn      (cpuClkEn),
  .perClkEn      (perClkEn),
  .oscRun        (oscRun),
  .addrStrobe    (addrStrobe),
  .progStrobe    (progStrobe),
  .wakePulse     (wakePulse),
  .cpuAddrStrobe (cpuAddrStrobe),
  .cpuProgStrobe (cpuProgStrobe)
);

// File: tb/test_pwrModeCtl.sv
`timescale 1ns/1ps
module test_pwrModeCtl;

  localparam int NEXT = 2;
  localparam int WAKE = 1024;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            regWrEn = 1'b0;
  logic [7:0]      regWrData = 8'h00;
  logic            intPending = 1'b0;
  logic [NEXT-1:0] extIntN = '1;
  logic [NEXT-1:0] extIntEn = 2'b11;
  logic [NEXT-1:0] extIntLevel = 2'b01;   // pin 0 level, pin 1 edge
  logic            cpuAddrStrobe = 1'b0;
  logic            cpuProgStrobe = 1'b1;
  logic            cpuClkEn, perClkEn, oscRun, addrStrobe, progStrobe, wakePulse;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    done    = 1'b0;
  string curTag  = "R1";

  always #5 clk = ~clk;

  pwrModeCtl #(.NEXT(NEXT), .WAKE_CYCLES(WAKE)) i_pwrModeCtl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .intPending(intPending), .extIntN(extIntN), .extIntEn(extIntEn),
    .extIntLevel(extIntLevel), .cpuAddrStrobe(cpuAddrStrobe),
    .cpuProgStrobe(cpuProgStrobe), .cpuClkEn(cpuClkEn), .perClkEn(perClkEn),
    .oscRun(oscRun), .addrStrobe(addrStrobe), .progStrobe(progStrobe),
    .wakePulse(wakePulse)
  );

  // behavioural reference: 0 run, 1 idle, 2 power-down
  int mSt = 0;
  int mLow = 0;
  bit mWake = 1'b0;

  function automatic bit qualLow();
    bit r = 1'b0;
    for (int i = 0; i < NEXT; i++)
      if (extIntEn[i] && extIntLevel[i] && !extIntN[i]) r = 1'b1;
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 0; mLow = 0; mWake = 1'b0;
    end else begin
      mWake = 1'b0;
      if (mSt == 0) begin
        mLow = 0;
        if (regWrEn && regWrData[1]) mSt = 2;
        else if (regWrEn && regWrData[0]) mSt = 1;
      end else if (mSt == 1) begin
        mLow = 0;
        if (intPending) begin mSt = 0; mWake = 1'b1; end
      end else begin
        if (qualLow()) begin
          if (mLow < WAKE) mLow++;
        end else begin
          if (mLow >= WAKE) begin mSt = 0; mWake = 1'b1; end
          mLow = 0;
        end
      end
    end
  end

  task automatic check(string tag, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      check(curTag, "cpuClkEn", cpuClkEn, mSt == 0);
      check(curTag, "perClkEn", perClkEn, mSt != 2);
      check(curTag, "oscRun", oscRun, (mSt != 2) || qualLow());
      check("R4", "addrStrobe", addrStrobe, (mSt == 0) ? cpuAddrStrobe : (mSt == 1));
      check("R4", "progStrobe", progStrobe, (mSt == 0) ? cpuProgStrobe : (mSt == 1));
      check("R10", "wakePulse", wakePulse, mWake);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0; regWrData = 8'h00;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state and run-mode strobe pass-through (R4)
    curTag = "R1";
    step(3); rstN = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1); cpuAddrStrobe = i[0]; cpuProgStrobe = i[1];
    end
    // R12: writes with neither mode bit set
    curTag = "R12";
    wr(8'h00); wr(8'hFC); step(3);
    // R2: enter idle; R12: writes while asleep ignored
    curTag = "R2";
    wr(8'h01); step(5);
    curTag = "R12";
    wr(8'h02); wr(8'h01); step(3);
    // R5: pending interrupt ends idle (R10 pulse)
    curTag = "R5";
    @(negedge clk); intPending = 1'b1;
    @(negedge clk); intPending = 1'b0;
    step(4);
    // R3: power-down
    curTag = "R3";
    wr(8'h02); step(4);
    // R6: ignored sources in power-down
    curTag = "R6";
    @(negedge clk); intPending = 1'b1; step(20); intPending = 1'b0;
    extIntN = 2'b01; step(WAKE + 10); extIntN = 2'b11; step(3);  // edge pin 1
    extIntEn = 2'b10; extIntN = 2'b10; step(WAKE + 10);          // disabled pin 0
    extIntN = 2'b11; extIntEn = 2'b11; step(3);
    // R7, R9: released one short of the window
    curTag = "R9";
    extIntN = 2'b10; step(300); extIntN = 2'b11; step(5);
    extIntN = 2'b10; step(WAKE - 1); extIntN = 2'b11; step(5);
    // R8: exactly the window, then release
    curTag = "R8";
    extIntN = 2'b10; step(WAKE); extIntN = 2'b11; step(5);
    // R3: both bits set picks power-down
    curTag = "R3";
    wr(8'h03); step(5);
    // R11: asynchronous reset during power-down and during idle
    curTag = "R11";
    #2 rstN = 1'b0; step(2); rstN = 1'b1; step(3);
    wr(8'h01); step(3);
    #2 rstN = 1'b0; step(2); rstN = 1'b1; step(4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule